// File: doc/BRIEF.md
# Save Memory Mode and Commit Controller

This block sits between a CPU bus and a cartridge's save memory. The save memory may be a byte-wide static RAM or a serial EEPROM. The static RAM and the EEPROM serial engine are both outside the block.

The block keeps a small mode register, which the CPU writes through one byte I/O address. It learns which kind of save memory the cartridge has from the first write that lands in the save window. For every access that falls inside the window, it decides whether the access goes to the RAM array, goes to the EEPROM engine, or is dropped. It also raises a sticky flag whenever a RAM write changes a stored byte.

EEPROM writes are coalesced. A write that comes too soon after the last commit only refreshes the engine's pending update. A later write first commits the pending update and then records its own update. A saturating cycle counter measures the spacing between commits.

All strobes are combinational in the cycle of the access. Mode, detection, dirty and timer state change at the clock edge that ends that cycle.

Top module: `sv_save_ctrl`

## Requirements
- R1: A byte write to address 0xA130F1 copies data bits 1:0 into mode bits 1:0 and leaves every other mode bit unchanged. In `mode_o`, bit 0 enables RAM reads, bit 1 write-protects the RAM, bit 2 marks EEPROM mode and bit 4 marks detected; all other bits read 0.
- R2: Any write inside the save window while bit 4 is clear sets bit 4.
- R3: Consider a write inside the window while bit 4 is clear whose address, ignoring bit 0, equals 0x200000. That write sets bit 2, and from the next cycle on the window is only 0x200000–0x200001. The write itself is still routed by the mode held before it.
- R4: A read inside the window sets bit 4 when all of these hold: bit 0 is set, bit 4 is clear, and the address is above 0x200001. A read at 0x200001 or below leaves bit 4 clear.
- R5: In EEPROM mode, every write inside the window pulses `ee_pend`. It also pulses `ee_commit` only when at least 46 cycles have passed since the last commit. A commit restarts the count; a write that only pulses `ee_pend` does not.
- R6: In EEPROM mode, a read inside the window pulses `ee_rd` and returns `ee_rdata` on `rd_data`, never touching the RAM.
- R7: Outside EEPROM mode, a read inside the window selects the RAM and returns `ram_rdata` only when bit 0 is set. Otherwise `ram_sel` stays low and `rd_data` is 0.
- R8: Outside EEPROM mode, a write inside the window asserts `ram_we` only when bit 1 is clear.
- R9: `dirty` rises after a RAM write whose data differs from `ram_rdata`, stays high until `dirty_clr`, and does not rise for a write of an equal byte.
- R10: Reset clears all mode bits, the commit timer and `dirty`.
- R11: An access outside the window (or to the mode address) asserts none of `ram_sel`, `ram_we`, `ee_rd`, `ee_pend`, `ee_commit` and leaves bits 2 and 4 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | A bus access is present this cycle |
| acc_wr | input | 1 | 1 write, 0 read |
| acc_addr | input | AW (24) | Byte address |
| acc_wdata | input | 8 | Write byte |
| ram_rdata | input | 8 | Byte currently stored at `ram_addr` |
| ee_rdata | input | 8 | Read byte from the EEPROM engine |
| dirty_clr | input | 1 | Clears the dirty flag |
| ram_sel | output | 1 | RAM array access this cycle |
| ram_we | output | 1 | RAM array write this cycle |
| ram_addr | output | SAVE_AW (16) | Offset of the access inside the window |
| ee_rd | output | 1 | Read served by the EEPROM engine |
| ee_pend | output | 1 | Engine records this write as its pending update |
| ee_commit | output | 1 | Engine executes its pending update first |
| rd_data | output | 8 | Read byte returned to the CPU |
| dirty | output | 1 | Sticky RAM-changed flag |
| mode_o | output | 8 | Mode register |

## Verification
Writes inside the window are tried in three forms: with equal data, with differing data, and under write protection. These tell a real change apart from a redundant store and from a blocked store.

Reads are tried with bit 0 clear and set, at 0x200001 and at a higher address. This separates RAM gating from the detection rule and its address boundary.

Detection is started by a write at 0x200001, followed by a read at 0x200002. This shows the bit-0-insensitive EEPROM match, the routing of the detecting write itself, and the shrunken window.

EEPROM writes are spaced 45 and 46 cycles after a commit, then back-to-back. This pins the exact threshold and shows that pending-only writes do not restart the spacing.

// File: rtl/sv_save_pkg.sv
package sv_save_pkg;
   localparam int unsigned MB_RDEN  = 0;
   localparam int unsigned MB_WPROT = 1;
   localparam int unsigned MB_EE    = 2;
   localparam int unsigned MB_FOUND = 4;

   typedef struct packed {
      logic found;
      logic ee;
      logic wprot;
      logic rden;
   } save_mode_t;

   function automatic logic [7:0] mode_to_byte(save_mode_t m);
      logic [7:0] b;
      b = 8'h00;
      b[MB_RDEN]  = m.rden;
      b[MB_WPROT] = m.wprot;
      b[MB_EE]    = m.ee;
      b[MB_FOUND] = m.found;
      return b;
   endfunction
endpackage

// File: rtl/sv_save_range.sv
module sv_save_range #(
   parameter int unsigned AW      = 24,
   parameter int unsigned SAVE_LO = 32'h0020_0000,
   parameter int unsigned SAVE_AW = 16,
   parameter int unsigned EE_ADDR = 32'h0020_0000
) (
   input  logic [AW-1:0]      addr,
   input  logic               ee_mode,
   output logic               hit,
   output logic [SAVE_AW-1:0] ofs
);
   localparam logic [AW:0]   LO_V  = (AW+1)'(SAVE_LO);
   localparam logic [AW:0]   HI_X  = (AW+1)'(SAVE_LO) + ((AW+1)'(1) << SAVE_AW);
   localparam logic [AW-1:0] EE_V  = AW'(EE_ADDR);
   localparam logic [AW-1:0] LO_AW = AW'(SAVE_LO);

   logic [AW:0]   addr_x;
   logic          hit_wide;
   logic          hit_pair;
   logic [AW-1:0] diff;

   assign addr_x   = {1'b0, addr};
   assign hit_wide = (addr_x >= LO_V) && (addr_x < HI_X);
   assign hit_pair = (addr[AW-1:1] == EE_V[AW-1:1]);
   assign hit      = ee_mode ? hit_pair : hit_wide;
   assign diff     = addr - LO_AW;
   assign ofs      = diff[SAVE_AW-1:0];
endmodule

// File: rtl/sv_save_mode.sv
module sv_save_mode
   import sv_save_pkg::*;
#(
   parameter int unsigned AW      = 24,
   parameter int unsigned EE_ADDR = 32'h0020_0000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mreg_wr,
   input  logic [1:0] mreg_data,
   input  logic       win_wr,
   input  logic       win_rd,
   input  logic [AW-1:0] addr,
   output save_mode_t mode
);
   localparam logic [AW-1:0] EE_V  = AW'(EE_ADDR);
   localparam logic [AW-1:0] EE_HI = AW'(EE_ADDR) + AW'(1);

   save_mode_t nxt;
   logic       ee_match;

   assign ee_match = (addr[AW-1:1] == EE_V[AW-1:1]);

   always_comb begin
      nxt = mode;
      if (mreg_wr) begin
         nxt.rden  = mreg_data[0];
         nxt.wprot = mreg_data[1];
      end
      if (win_wr && !mode.found) begin
         nxt.found = 1'b1;
         if (ee_match) nxt.ee = 1'b1;
      end
      if (win_rd && mode.rden && !mode.found && (addr > EE_HI))
         nxt.found = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mode <= '0;
      else        mode <= nxt;
   end
endmodule

// File: rtl/sv_commit_gap.sv
module sv_commit_gap #(
   parameter int unsigned GAP = 46
) (
   input  logic clk,
   input  logic rst_n,
   input  logic commit,
   output logic ready
);
   generate
      if (GAP == 0) begin : g_none
         assign ready = 1'b1;
      end else begin : g_cnt
         localparam int unsigned CW = $clog2(GAP + 1);
         localparam logic [CW-1:0] LIM = CW'(GAP);
         logic [CW-1:0] cnt;
         assign ready = (cnt >= LIM);
         always_ff @(posedge clk) begin
            if (!rst_n)          cnt <= '0;
            else if (commit)     cnt <= CW'(1);
            else if (cnt < LIM)  cnt <= cnt + CW'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/sv_save_ctrl.sv
module sv_save_ctrl
   import sv_save_pkg::*;
#(
   parameter int unsigned AW        = 24,
   parameter int unsigned SAVE_LO   = 32'h0020_0000,
   parameter int unsigned SAVE_AW   = 16,
   parameter int unsigned EE_ADDR   = 32'h0020_0000,
   parameter int unsigned MODE_ADDR = 32'h00A1_30F1,
   parameter int unsigned GAP       = 46
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_vld,
   input  logic               acc_wr,
   input  logic [AW-1:0]      acc_addr,
   input  logic [7:0]         acc_wdata,
   input  logic [7:0]         ram_rdata,
   input  logic [7:0]         ee_rdata,
   input  logic               dirty_clr,
   output logic               ram_sel,
   output logic               ram_we,
   output logic [SAVE_AW-1:0] ram_addr,
   output logic               ee_rd,
   output logic               ee_pend,
   output logic               ee_commit,
   output logic [7:0]         rd_data,
   output logic               dirty,
   output logic [7:0]         mode_o
);
   localparam logic [AW-1:0] MODE_V = AW'(MODE_ADDR);

   initial begin
      assert (AW >= 8 && AW <= 32) else $error("AW out of range");
      assert (SAVE_AW >= 1 && SAVE_AW < AW) else $error("SAVE_AW out of range");
      assert (GAP < 65536) else $error("GAP too large");
   end

   save_mode_t mode;
   logic       hit;
   logic       wr_acc, rd_acc;
   logic       win_wr, win_rd;
   logic       mreg_wr;
   logic       gap_ok;
   logic       ram_rd;

   assign wr_acc  = acc_vld &&  acc_wr;
   assign rd_acc  = acc_vld && !acc_wr;
   assign mreg_wr = wr_acc && (acc_addr == MODE_V);

   sv_save_range #(
      .AW(AW), .SAVE_LO(SAVE_LO), .SAVE_AW(SAVE_AW), .EE_ADDR(EE_ADDR)
   ) u_range (
      .addr(acc_addr), .ee_mode(mode.ee), .hit(hit), .ofs(ram_addr)
   );

   assign win_wr = wr_acc && hit;
   assign win_rd = rd_acc && hit;

   sv_save_mode #(
      .AW(AW), .EE_ADDR(EE_ADDR)
   ) u_mode (
      .clk(clk), .rst_n(rst_n), .mreg_wr(mreg_wr), .mreg_data(acc_wdata[1:0]),
      .win_wr(win_wr), .win_rd(win_rd), .addr(acc_addr), .mode(mode)
   );

   sv_commit_gap #(.GAP(GAP)) u_gap (
      .clk(clk), .rst_n(rst_n), .commit(ee_commit), .ready(gap_ok)
   );

   assign ee_pend   = win_wr && mode.ee;
   assign ee_commit = ee_pend && gap_ok;
   assign ee_rd     = win_rd && mode.ee;
   assign ram_we    = win_wr && !mode.ee && !mode.wprot;
   assign ram_rd    = win_rd && !mode.ee && mode.rden;
   assign ram_sel   = ram_we || ram_rd;

   always_comb begin
      if (ee_rd)       rd_data = ee_rdata;
      else if (ram_rd) rd_data = ram_rdata;
      else             rd_data = 8'h00;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                                  dirty <= 1'b0;
      else if (ram_we && (acc_wdata != ram_rdata)) dirty <= 1'b1;
      else if (dirty_clr)                          dirty <= 1'b0;
   end

   assign mode_o = mode_to_byte(mode);
endmodule

// File: rtl/sv_save_chk.sv
module sv_save_chk #(
   parameter int unsigned AW        = 24,
   parameter int unsigned MODE_ADDR = 32'h00A1_30F1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          acc_vld,
   input logic          acc_wr,
   input logic [AW-1:0] acc_addr,
   input logic [7:0]    acc_wdata,
   input logic          dirty_clr,
   input logic          ram_sel,
   input logic          ram_we,
   input logic          ee_rd,
   input logic          ee_pend,
   input logic          ee_commit,
   input logic          dirty,
   input logic [7:0]    mode_o
);
   localparam logic [AW-1:0] MODE_V = AW'(MODE_ADDR);

   // R1
   mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && acc_wr && acc_addr == MODE_V) |=> (mode_o[1:0] == $past(acc_wdata[1:0])));

   // R2
   found_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o[4] |=> mode_o[4]);

   // R5
   commit_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ee_commit |-> ee_pend);

   // R5
   commit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ee_commit |=> !ee_commit);

   // R6
   ee_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o[2] |-> !ram_sel);

   // R8
   wprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (!mode_o[1] && !mode_o[2]));

   // R9
   dirty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dirty && !dirty_clr) |=> dirty);

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_vld |-> !(ram_sel || ram_we || ee_rd || ee_pend || ee_commit));
endmodule

bind sv_save_ctrl sv_save_chk #(.AW(AW), .MODE_ADDR(MODE_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
   .acc_addr(acc_addr), .acc_wdata(acc_wdata), .dirty_clr(dirty_clr),
   .ram_sel(ram_sel), .ram_we(ram_we), .ee_rd(ee_rd), .ee_pend(ee_pend),
   .ee_commit(ee_commit), .dirty(dirty), .mode_o(mode_o)
);

// File: tb/tb_sv_save_ctrl.sv
module tb_sv_save_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_vld = 1'b0, acc_wr = 1'b0;
   logic [23:0] acc_addr = '0;
   logic [7:0]  acc_wdata = '0, ram_rdata = '0, ee_rdata = '0;
   logic        dirty_clr = 1'b0;
   logic        ram_sel, ram_we, ee_rd, ee_pend, ee_commit, dirty;
   logic [15:0] ram_addr;
   logic [7:0]  rd_data, mode_o;

   int tests = 0, fails = 0;
   logic s_sel, s_we, s_erd, s_pend, s_com;
   logic [7:0] s_rd;

   always #5 clk = ~clk;

   sv_save_ctrl dut (
      .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .ram_rdata(ram_rdata),
      .ee_rdata(ee_rdata), .dirty_clr(dirty_clr), .ram_sel(ram_sel),
      .ram_we(ram_we), .ram_addr(ram_addr), .ee_rd(ee_rd), .ee_pend(ee_pend),
      .ee_commit(ee_commit), .rd_data(rd_data), .dirty(dirty), .mode_o(mode_o)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; acc_vld = 1'b0; dirty_clr = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // one access over one rising edge; strobes captured before that edge
   task automatic access(logic wr, logic [23:0] a, logic [7:0] d, logic [7:0] stored);
      acc_vld = 1'b1; acc_wr = wr; acc_addr = a; acc_wdata = d; ram_rdata = stored;
      #1;
      s_sel = ram_sel; s_we = ram_we; s_erd = ee_rd; s_pend = ee_pend;
      s_com = ee_commit; s_rd = rd_data;
      @(negedge clk);
      acc_vld = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      check("R10 mode after reset", mode_o, 8'h00);
      check("R10 dirty after reset", dirty, 0);
   endtask

   task automatic t_mode_reg();
      do_reset();
      access(1, 24'hA130F1, 8'hFF, 8'h00);
      check("R1 mode bits 1:0 only", mode_o, 8'h03);
      check("R11 mode addr no strobe", {s_sel, s_we, s_erd, s_pend, s_com}, 0);
      access(1, 24'hA130F1, 8'hFE, 8'h00);
      check("R1 mode rewrite", mode_o, 8'h02);
   endtask

   task automatic t_sram_read();
      do_reset();
      access(0, 24'h200010, 8'h00, 8'h5A);
      check("R7 read gated sel", s_sel, 0);
      check("R7 read gated data", s_rd, 8'h00);
      check("R4 no detect without bit0", mode_o[4], 0);
      access(1, 24'hA130F1, 8'h01, 8'h00);
      access(0, 24'h200001, 8'h00, 8'h5A);
      check("R7 read enabled sel", s_sel, 1);
      check("R7 read enabled data", s_rd, 8'h5A);
      check("R4 boundary no detect", mode_o[4], 0);
      access(0, 24'h200002, 8'h00, 8'h77);
      check("R4 detect above boundary", mode_o, 8'h11);
   endtask

   task automatic t_sram_write();
      do_reset();
      access(1, 24'h200100, 8'h33, 8'h33);
      check("R8 write allowed", s_we, 1);
      check("R2 first write detects", mode_o, 8'h10);
      check("R9 equal byte clean", dirty, 0);
      access(1, 24'h200102, 8'h44, 8'h33);
      check("R9 diff byte dirty", dirty, 1);
      idle(3);
      check("R9 dirty sticky", dirty, 1);
      dirty_clr = 1'b1; @(negedge clk); dirty_clr = 1'b0;
      check("R9 dirty cleared", dirty, 0);
      access(1, 24'hA130F1, 8'h02, 8'h00);
      access(1, 24'h200104, 8'h99, 8'h11);
      check("R8 protected no we", s_we, 0);
      check("R8 protected no dirty", dirty, 0);
   endtask

   task automatic t_outside();
      do_reset();
      access(1, 24'h1FFFFF, 8'h12, 8'h00);
      check("R11 below window", {s_sel, s_we, s_erd, s_pend, s_com}, 0);
      access(1, 24'h210000, 8'h12, 8'h00);
      check("R11 above window", {s_sel, s_we, s_erd, s_pend, s_com}, 0);
      check("R11 no detect", mode_o, 8'h00);
   endtask

   task automatic t_eeprom();
      do_reset();
      ee_rdata = 8'hC3;
      access(1, 24'h200001, 8'h01, 8'h00);
      check("R3 detecting write uses old mode", {s_we, s_pend}, 2'b10);
      check("R3 eeprom mode set", mode_o, 8'h14);
      access(0, 24'h200000, 8'h00, 8'h00);
      check("R6 eeprom read strobe", {s_erd, s_sel}, 2'b10);
      check("R6 eeprom read data", s_rd, 8'hC3);
      access(0, 24'h200002, 8'h00, 8'h00);
      check("R3 window shrunk", {s_sel, s_we, s_erd, s_pend, s_com}, 0);
      idle(60);
      access(1, 24'h200000, 8'h01, 8'h00);
      check("R5 spaced write commits", {s_pend, s_com}, 2'b11);
      idle(44);
      access(1, 24'h200001, 8'h00, 8'h00);
      check("R5 45 cycles pend only", {s_pend, s_com}, 2'b10);
      access(1, 24'h200000, 8'h01, 8'h00);
      check("R5 46 cycles commits", {s_pend, s_com}, 2'b11);
      access(1, 24'h200000, 8'h00, 8'h00);
      check("R5 back to back pend only", {s_pend, s_com}, 2'b10);
   endtask

   initial begin
      #(20_000 * 10);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_mode_reg();
      t_sram_read();
      t_sram_write();
      t_outside();
      t_eeprom();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule